// File: doc/BRIEF.md
# DMA Controller Host Register File

This block is the processor-facing register file of a four-channel byte DMA engine on an 8-bit bus. A 5-bit register address with separate read and write strobes selects one register. Each channel has a 16-bit memory address and a 16-bit transfer count. There are also four channel control registers and three shared registers: priority/enable, interrupt and chain. The address, count, configuration and enable values go to the transfer sequencer on dedicated outputs.

Status bits cannot be written from the host. The sequencer sets them through one-cycle busy and done pulses per channel. The host clears them by reading. A channel control read clears that channel's end-of-transfer flag. An interrupt register read returns the pending flag together with the completion bit kept in the chain register's upper half. The same read clears both and drops every interrupt line. Read data is registered: it appears on the cycle after the read strobe and holds until the next read.

Top module: `dma_host_regs`

## Requirements
- R1: Addresses 0x00-0x0F reach the per-channel registers. Address bits [3:2] give the channel. Bits [1:0] = 0, 1, 2, 3 select address high byte, address low byte, count high byte and count low byte. Each byte is written and read back unchanged, and the 16-bit values appear on `ch_addr_o`/`ch_count_o`, with channel n in bits [16n+15:16n].
- R2: After reset every address and count register is 0xFFFF. Control, priority, interrupt and chain registers are 0x00, `irq_o` and `xfer_en_o` are low, and `rdata_o` is 0x00.
- R3: A write to control register 0x10+n changes only bits [3:0]. Bits [7:6] (7 = done, 6 = busy) keep their value and bits [5:4] read 0. Bits [3:0] of channel n appear on `ch_cfg_o[4n+3:4n]`.
- R4: A read of control register 0x10+n returns its value before the read and clears bit 7. Bit 6 is kept.
- R5: The priority register at 0x14 stores the written byte ANDed with 0x8F. Its bit 0 drives `xfer_en_o`.
- R6: A write to the interrupt register at 0x15 changes bits [3:0] (enable for channel n at bit n) and keeps bit 7 (pending).
- R7: A read of 0x15 returns ({4'h0, chain[7:4]} | 0x80) & intr. The same read clears intr bit 7, clears chain bits [7:4] and drives all of `irq_o` low.
- R8: A pulse on `busy_set_i[n]` sets control bit 6 of channel n. A pulse on `done_set_i[n]` sets control bit 7, clears bit 6 and sets chain bit 4. If intr enable bit n is set, it also sets intr bit 7 and `irq_o[n]`; otherwise `irq_o` is unchanged.
- R9: The chain register at 0x16 takes writes to bits [3:0] only, and a read returns only bits [3:0]. Bits [3:0] also drive `chain_cfg_o`.
- R10: Addresses 0x17-0x1F read as 0xFF, and writes to them change no register.
- R11: `rdata_o` carries the read value on the cycle after the read strobe and holds it until the next read. A done pulse in the same cycle as a clearing read takes precedence, so the flag is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register address |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| busy_set_i | input | 4 | Sequencer: channel started |
| done_set_i | input | 4 | Sequencer: channel finished |
| ch_addr_o | output | 64 | Address register of each channel |
| ch_count_o | output | 64 | Count register of each channel |
| ch_cfg_o | output | 16 | Control bits [3:0] of each channel |
| chain_cfg_o | output | 4 | Chain register bits [3:0] |
| xfer_en_o | output | 1 | Global transfer enable |
| irq_o | output | 4 | Interrupt line of each channel |

## Verification
Register writes, status-set pulses and read-clear side effects take effect at the clock edge that samples the strobe. The configuration outputs and `irq_o` therefore show the new value one edge after the stimulus. `rdata_o` is loaded at the edge that samples `rd_i`, with the value from before any clear. The bench drives every strobe on a falling edge, removes it on the next falling edge, and samples outputs there, exactly one rising edge later. A read that follows a clearing read observes the cleared state.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 8;
  localparam int REG_W    = 16;
  localparam int NUM_CH   = 4;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int CFG_W    = 4;

  localparam logic [ADDR_W-1:0] A_CTRL0 = 5'h10;
  localparam logic [ADDR_W-1:0] A_PRIO  = 5'h14;
  localparam logic [ADDR_W-1:0] A_INTR  = 5'h15;
  localparam logic [ADDR_W-1:0] A_CHAIN = 5'h16;

  localparam logic [DATA_W-1:0] PRIO_MASK = 8'h8F;
  localparam logic [DATA_W-1:0] UNMAPPED  = 8'hFF;

  typedef enum logic [1:0] {
    SEL_ADDR_HI = 2'd0,
    SEL_ADDR_LO = 2'd1,
    SEL_CNT_HI  = 2'd2,
    SEL_CNT_LO  = 2'd3
  } chan_sel_e;
endpackage

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
  import dma_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  chan_sel_e         sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [REG_W-1:0]  addr_o,
  output logic [REG_W-1:0]  count_o
);
  localparam int HALF = REG_W / 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '1;
      count_o <= '1;
    end else if (wr_i) begin
      unique case (sel_i)
        SEL_ADDR_HI: addr_o[REG_W-1:HALF]  <= wdata_i;
        SEL_ADDR_LO: addr_o[HALF-1:0]      <= wdata_i;
        SEL_CNT_HI:  count_o[REG_W-1:HALF] <= wdata_i;
        SEL_CNT_LO:  count_o[HALF-1:0]     <= wdata_i;
      endcase
    end
  end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_regs_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CH-1:0]              wr_i,
  input  logic [NUM_CH-1:0]              rd_i,
  input  logic [CFG_W-1:0]               wdata_i,
  input  logic [NUM_CH-1:0]              busy_set_i,
  input  logic [NUM_CH-1:0]              done_set_i,
  output logic [NUM_CH-1:0][DATA_W-1:0]  ctrl_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] nxt;

    always_comb begin
      nxt = ctrl_o[c];
      if (wr_i[c]) nxt = {ctrl_o[c][7:6], 2'b00, wdata_i};
      if (rd_i[c]) nxt[7] = 1'b0;
      if (busy_set_i[c]) nxt[6] = 1'b1;
      // completion wins over both busy and a clearing read
      if (done_set_i[c]) begin
        nxt[7] = 1'b1;
        nxt[6] = 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_o[c] <= '0;
      else         ctrl_o[c] <= nxt;
    end

    AST_CTRL_WR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i[c] && !rd_i[c] && !busy_set_i[c] && !done_set_i[c])
      |=> ctrl_o[c][7:6] == $past(ctrl_o[c][7:6])); // R3
    AST_CTRL_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i[c] && !done_set_i[c]) |=> !ctrl_o[c][7]); // R4
    AST_DONE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_set_i[c] |=> ctrl_o[c][7] && !ctrl_o[c][6]); // R11
  end
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              intr_wr_i,
  input  logic              intr_rd_i,
  input  logic              chain_wr_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic [NUM_CH-1:0] done_set_i,
  output logic [DATA_W-1:0] intr_o,
  output logic [DATA_W-1:0] chain_o,
  output logic [DATA_W-1:0] intr_rd_val_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] fire;
  logic              any_done;

  assign fire     = done_set_i & intr_o[NUM_CH-1:0];
  assign any_done = |done_set_i;
  assign intr_rd_val_o = ({4'h0, chain_o[7:4]} | 8'h80) & intr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      intr_o  <= '0;
      chain_o <= '0;
      irq_o   <= '0;
    end else begin
      if (intr_wr_i) intr_o[CFG_W-1:0] <= wdata_i;
      if (chain_wr_i) chain_o[CFG_W-1:0] <= wdata_i;
      if (intr_rd_i) begin
        intr_o[7]     <= 1'b0;
        chain_o[7:4]  <= 4'h0;
      end
      if (any_done) chain_o[4] <= 1'b1;
      if (|fire) intr_o[7] <= 1'b1;
      irq_o <= (intr_rd_i ? '0 : irq_o) | fire;
    end
  end

  AST_IRQ_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_rd_i && done_set_i == '0) |=> irq_o == '0); // R7
  AST_INTR_WR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_wr_i && !intr_rd_i && done_set_i == '0) |=> intr_o[7] == $past(intr_o[7])); // R6
  for (genvar c = 0; c < NUM_CH; c++) begin : g_irq_chk
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[c]) |-> $past(intr_o[c])); // R8
  end
endmodule

// File: rtl/dma_host_regs.sv
module dma_host_regs
  import dma_regs_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  input  logic [NUM_CH-1:0]         busy_set_i,
  input  logic [NUM_CH-1:0]         done_set_i,
  output logic [NUM_CH*REG_W-1:0]   ch_addr_o,
  output logic [NUM_CH*REG_W-1:0]   ch_count_o,
  output logic [NUM_CH*CFG_W-1:0]   ch_cfg_o,
  output logic [CFG_W-1:0]          chain_cfg_o,
  output logic                      xfer_en_o,
  output logic [NUM_CH-1:0]         irq_o
);
  localparam int HALF = REG_W / 2;

  logic [NUM_CH-1:0][REG_W-1:0]  addr_q, count_q;
  logic [NUM_CH-1:0][DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0]             prio_q, intr_q, chain_q, intr_rd_val;
  logic [NUM_CH-1:0]             bank_wr, ctrl_wr, ctrl_rd;
  logic                          is_chan, is_ctrl;
  logic [CH_W-1:0]               ch_idx;
  logic [DATA_W-1:0]             rd_val;

  assign is_chan = (addr_i[4] == 1'b0);
  assign is_ctrl = (addr_i[4:2] == A_CTRL0[4:2]);
  assign ch_idx  = is_chan ? addr_i[3:2] : addr_i[1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign bank_wr[c] = wr_i && is_chan && (ch_idx == CH_W'(c));
    assign ctrl_wr[c] = wr_i && is_ctrl && (ch_idx == CH_W'(c));
    assign ctrl_rd[c] = rd_i && is_ctrl && (ch_idx == CH_W'(c));

    dma_chan_bank u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (bank_wr[c]),
      .sel_i   (chan_sel_e'(addr_i[1:0])),
      .wdata_i (wdata_i),
      .addr_o  (addr_q[c]),
      .count_o (count_q[c])
    );

    assign ch_addr_o[c*REG_W +: REG_W]  = addr_q[c];
    assign ch_count_o[c*REG_W +: REG_W] = count_q[c];
    assign ch_cfg_o[c*CFG_W +: CFG_W]   = ctrl_q[c][CFG_W-1:0];
  end

  dma_ctrl_regs u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ctrl_wr),
    .rd_i       (ctrl_rd),
    .wdata_i    (wdata_i[CFG_W-1:0]),
    .busy_set_i (busy_set_i),
    .done_set_i (done_set_i),
    .ctrl_o     (ctrl_q)
  );

  dma_irq_regs u_irq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .intr_wr_i     (wr_i && addr_i == A_INTR),
    .intr_rd_i     (rd_i && addr_i == A_INTR),
    .chain_wr_i    (wr_i && addr_i == A_CHAIN),
    .wdata_i       (wdata_i[CFG_W-1:0]),
    .done_set_i    (done_set_i),
    .intr_o        (intr_q),
    .chain_o       (chain_q),
    .intr_rd_val_o (intr_rd_val),
    .irq_o         (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     prio_q <= '0;
    else if (wr_i && addr_i == A_PRIO) prio_q <= wdata_i & PRIO_MASK;
  end

  assign xfer_en_o   = prio_q[0];
  assign chain_cfg_o = chain_q[CFG_W-1:0];

  always_comb begin
    rd_val = UNMAPPED;
    if (is_chan) begin
      unique case (chan_sel_e'(addr_i[1:0]))
        SEL_ADDR_HI: rd_val = addr_q[ch_idx][REG_W-1:HALF];
        SEL_ADDR_LO: rd_val = addr_q[ch_idx][HALF-1:0];
        SEL_CNT_HI:  rd_val = count_q[ch_idx][REG_W-1:HALF];
        SEL_CNT_LO:  rd_val = count_q[ch_idx][HALF-1:0];
      endcase
    end else if (is_ctrl) begin
      rd_val = ctrl_q[ch_idx];
    end else if (addr_i == A_PRIO) begin
      rd_val = prio_q;
    end else if (addr_i == A_INTR) begin
      rd_val = intr_rd_val;
    end else if (addr_i == A_CHAIN) begin
      rd_val = {4'h0, chain_q[CFG_W-1:0]};
    end
  end

  // value captured before the same-edge clear lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end

  AST_UNMAPPED_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i > A_CHAIN) |=> rdata_o == UNMAPPED); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R11
  AST_PRIO_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_PRIO) |=> prio_q[6:4] == 3'b000); // R5
endmodule

// File: tb/dma_host_regs_test.sv
module dma_host_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  busy_set = '0, done_set = '0;
  logic [63:0] ch_addr, ch_count;
  logic [15:0] ch_cfg;
  logic [3:0]  chain_cfg;
  logic        xfer_en;
  logic [3:0]  irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0] got;

  always #4 clk = ~clk;

  dma_host_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .busy_set_i(busy_set),
    .done_set_i(done_set), .ch_addr_o(ch_addr), .ch_count_o(ch_count),
    .ch_cfg_o(ch_cfg), .chain_cfg_o(chain_cfg), .xfer_en_o(xfer_en),
    .irq_o(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [3:0] b, input logic [3:0] dn);
    @(negedge clk); busy_set = b; done_set = dn;
    @(negedge clk); busy_set = '0; done_set = '0;
  endtask

  // {rd, addr, data/expected}; tag in comment
  localparam int NV = 28;
  localparam logic [13:0] VECS [0:NV-1] = '{
    {1'b0, 5'h00, 8'h12}, {1'b0, 5'h01, 8'h34}, {1'b0, 5'h02, 8'h56},
    {1'b0, 5'h03, 8'h78}, {1'b0, 5'h0C, 8'hAB}, {1'b0, 5'h0F, 8'hCD},
    {1'b1, 5'h00, 8'h12}, {1'b1, 5'h01, 8'h34}, {1'b1, 5'h02, 8'h56},   // R1
    {1'b1, 5'h03, 8'h78}, {1'b1, 5'h0C, 8'hAB}, {1'b1, 5'h0D, 8'hFF},   // R1
    {1'b1, 5'h0E, 8'hFF}, {1'b1, 5'h0F, 8'hCD}, {1'b1, 5'h04, 8'hFF},   // R1 R2
    {1'b0, 5'h11, 8'hFF}, {1'b1, 5'h11, 8'h0F},                         // R3
    {1'b0, 5'h14, 8'hFF}, {1'b1, 5'h14, 8'h8F},                         // R5
    {1'b0, 5'h15, 8'hFF}, {1'b1, 5'h15, 8'h00},                         // R7
    {1'b0, 5'h16, 8'hFF}, {1'b1, 5'h16, 8'h0F},                         // R9
    {1'b0, 5'h17, 8'h55}, {1'b1, 5'h17, 8'hFF}, {1'b1, 5'h1F, 8'hFF},   // R10
    {1'b1, 5'h14, 8'h8F}, {1'b1, 5'h16, 8'h0F}                          // R10
  };

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2 addr", ch_addr, {64{1'b1}});
    check("R2 count", ch_count, {64{1'b1}});
    check("R2 irq", irq, 4'h0);
    check("R2 xfer_en", xfer_en, 1'b0);
    check("R2 rdata", rdata, 8'h00);
    check("R2 cfg", ch_cfg, 16'h0);
    rd_reg(5'h13, got); check("R2 ctrl3", got, 8'h00);
    rd_reg(5'h15, got); check("R2 intr", got, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][13]) begin
        rd_reg(VECS[i][12:8], got);
        check($sformatf("vec%0d", i), got, VECS[i][7:0]);
      end else begin
        wr_reg(VECS[i][12:8], VECS[i][7:0]);
      end
    end

    check("R1 ch_addr0", ch_addr[15:0], 16'h1234);
    check("R1 ch_count0", ch_count[15:0], 16'h5678);
    check("R1 ch_addr3", ch_addr[63:48], 16'hABFF);
    check("R3 cfg1", ch_cfg[7:4], 4'hF);
    check("R5 xfer_en", xfer_en, 1'b1);
    check("R9 chain_cfg", chain_cfg, 4'hF);

    // R8 busy, then done with enable set
    pulse(4'b0010, 4'b0000);
    rd_reg(5'h11, got); check("R8 busy", got, 8'h4F);
    pulse(4'b0000, 4'b0010);
    check("R8 irq1", irq, 4'b0010);
    rd_reg(5'h11, got); check("R4 done read", got, 8'h8F);
    rd_reg(5'h11, got); check("R4 done cleared", got, 8'h0F);
    rd_reg(5'h15, got); check("R7 intr pend", got, 8'h81);
    check("R7 irq cleared", irq, 4'h0);
    rd_reg(5'h15, got); check("R7 intr after clr", got, 8'h00);
    rd_reg(5'h16, got); check("R9 chain low kept", got, 8'h0F);

    // R6 enable rewrite keeps pending bit
    pulse(4'b0000, 4'b0100);
    check("R8 irq2", irq, 4'b0100);
    wr_reg(5'h15, 8'h01);
    check("R6 irq kept", irq, 4'b0100);
    rd_reg(5'h15, got); check("R6 intr", got, 8'h81);

    // R8 done with enable cleared: no interrupt
    pulse(4'b0000, 4'b1000);
    check("R8 irq masked", irq, 4'h0);
    rd_reg(5'h15, got); check("R8 no pend", got, 8'h01);

    // R11 done in the same cycle as clearing read
    @(negedge clk); addr = 5'h10; rd = 1'b1; done_set = 4'b0001;
    @(negedge clk); rd = 1'b0; done_set = '0;
    check("R11 pre-clear value", rdata, 8'h00);
    rd_reg(5'h10, got); check("R11 set wins", got, 8'h80);
    rd_reg(5'h10, got); check("R4 ctrl0 cleared", got, 8'h00);

    // R11 read data holds
    rd_reg(5'h00, got);
    repeat (3) @(negedge clk);
    check("R11 hold", rdata, 8'h12);

    wr_reg(5'h14, 8'h00);
    check("R5 xfer_en off", xfer_en, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule